// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block sits between a host register port and a CAN bit engine. It owns a set of transmit mailboxes (four by default). For each mailbox the host writes a configuration word that carries an enable bit and a 4-bit urgency value, an identifier word, two data words and a control word. A control word with the start bit set arms the mailbox. The arbiter then decides which armed mailbox goes out next and hands that frame to the engine through a plain valid/done/abort handshake.

Selection uses the software urgency and not the CAN identifier. The smallest value wins, and a tie goes to the lowest mailbox number. A new choice is made only while the engine is idle, so a frame already handed over always runs to its end. When a frame ends, by completion, by engine abort or by host cancel, the mailbox's ready and abort flags are updated and its interrupt bit is raised. The interrupt bit holds until the host acknowledges it.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset every mailbox reads ready=1, abort=0 and interrupt=0, and txValid is 0.
- R2: A control write (register select 4) with bit 23 set arms the mailbox only if its configuration enable bit (bit 8 of register select 0) is 1 and the mailbox is ready. Arming clears ready and abort. A start on a disabled mailbox leaves ready at 1 and presents nothing. While a mailbox is in flight its ready flag stays 0.
- R3: The presented frame carries the identifier word (30 bits, bit 29 marks an extended identifier), the length code taken from bits 19:16 of the start write, the remote flag from bit 20, and 64 data bits with the high word (select 3) above the low word (select 2). txMb names the mailbox.
- R4: Among armed mailboxes the one with the smallest urgency value (bits 3:0 of the configuration word, 0 most urgent, 15 least) is presented first.
- R5: Among armed mailboxes sharing the smallest urgency value, the lowest mailbox number is presented first.
- R6: Once txValid is high, txMb and the frame stay unchanged until txDone or txAbort, even if a more urgent mailbox is armed meanwhile.
- R7: txDone while txValid ends the transfer: txValid drops on the next cycle, and that mailbox shows ready=1, abort=0 and its interrupt bit set.
- R8: txAbort (without txDone) while txValid ends the transfer with ready=1, abort=1 and the interrupt bit set.
- R9: An identifier write (register select 1) takes effect only while the mailbox enable bit is 0. Otherwise it is ignored.
- R10: A control write with bit 23 clear and bit 22 set cancels an armed mailbox that has not yet been presented: ready=1, abort=1, interrupt set, and it is never presented. The same write on the mailbox in flight has no effect.
- R11: A mailbox interrupt bit (bit index equal to the mailbox number) stays set until the matching irqAck bit is high for a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrMb | input | 2 | Mailbox addressed by the write |
| wrReg | input | 3 | Register select: 0 config, 1 identifier, 2 data low, 3 data high, 4 control |
| wrData | input | 32 | Host write data |
| irqAck | input | 4 | Per-mailbox interrupt acknowledge |
| mbReady | output | 4 | Per-mailbox ready flag |
| mbAbort | output | 4 | Per-mailbox abort flag |
| irqPend | output | 4 | Per-mailbox interrupt status |
| txValid | output | 1 | Frame presented to the bit engine |
| txMb | output | 2 | Mailbox of the presented frame |
| txIdWord | output | 30 | Identifier word of the presented frame |
| txRemote | output | 1 | Remote-request flag of the presented frame |
| txLen | output | 4 | Length code of the presented frame |
| txData | output | 64 | Payload of the presented frame |
| txDone | input | 1 | Engine reports successful end of the frame |
| txAbort | input | 1 | Engine reports aborted end of the frame |

## Verification
The selection logic is driven with armed sets of one to three mailboxes. The sets cover strictly ordered urgency values, where only the comparison matters, and equal values at different positions, where only the index tie-break matters. Some sets put the most urgent mailbox at a high index, which separates a true minimum search from a fixed index order. Each set is armed while another frame keeps the engine busy, so all members compete at once. The whole set is then drained and checked against the expected order. Directed sequences arm a more urgent mailbox during a transfer, which shows that no pre-emption occurs, and issue cancels on waiting and in-flight mailboxes. They also write identifiers with the mailbox enabled and disabled, which shows whether the identifier guard and the field placement are right.

// File: rtl/can_txarb_pkg.sv
`timescale 1ns/1ps
package can_txarb_pkg;

  // host register selects
  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_ID   = 3'd1,
    REG_DLO  = 3'd2,
    REG_DHI  = 3'd3,
    REG_CTRL = 3'd4
  } hostReg_e;

  // control word fields
  localparam int CTRL_START_BIT  = 23;
  localparam int CTRL_CANCEL_BIT = 22;
  localparam int CTRL_RTR_BIT    = 20;
  localparam int CTRL_LEN_LSB    = 16;
  // configuration word fields
  localparam int CFG_EN_BIT      = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grant;
    logic finishOk;
    logic finishAbort;
  } arbStrobe_t;

endpackage

// File: rtl/can_txarb_pick.sv
`timescale 1ns/1ps
module can_txarb_pick #(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0]             req,
  input  logic [NUM_MB-1:0][PRIO_W-1:0] prio,
  output logic                          found,
  output logic [IDX_W-1:0]              win
);

  logic [PRIO_W-1:0] bestPrio;

  // linear scan: strict less-than keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    win      = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (req[i] && (!found || (prio[i] < bestPrio))) begin
        found    = 1'b1;
        bestPrio = prio[i];
        win      = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/can_txarb_ctrl.sv
`timescale 1ns/1ps
module can_txarb_ctrl
  import can_txarb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MB-1:0]             pendVec,
  input  logic [NUM_MB-1:0]             cancelVec,
  input  logic [NUM_MB-1:0][PRIO_W-1:0] prio,
  input  logic                          txDone,
  input  logic                          txAbort,
  output arbStrobe_t                    strobe,
  output logic [IDX_W-1:0]              grantMb,
  output logic [IDX_W-1:0]              curMb,
  output logic                          busy
);

  arbState_e        state;
  logic [NUM_MB-1:0] eligible;
  logic             anyEligible;

  // a mailbox being cancelled this cycle may not be granted
  assign eligible = pendVec & ~cancelVec;

  can_txarb_pick #(
    .NUM_MB(NUM_MB),
    .PRIO_W(PRIO_W)
  ) u_pick (
    .req  (eligible),
    .prio (prio),
    .found(anyEligible),
    .win  (grantMb)
  );

  always_comb begin
    strobe.grant       = (state == ST_IDLE) && anyEligible;
    strobe.finishOk    = (state == ST_BUSY) && txDone;
    strobe.finishAbort = (state == ST_BUSY) && !txDone && txAbort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curMb <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.grant) begin
          state <= ST_BUSY;
          curMb <= grantMb;
        end
        ST_BUSY: if (strobe.finishOk || strobe.finishAbort) begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/can_txarb_dp.sv
`timescale 1ns/1ps
module can_txarb_dp
  import can_txarb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  parameter int ID_W   = 30,
  parameter int LEN_W  = 4,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [IDX_W-1:0]              wrMb,
  input  logic [2:0]                    wrReg,
  input  logic [WORD_W-1:0]             wrData,
  input  logic [NUM_MB-1:0]             irqAck,
  input  arbStrobe_t                    strobe,
  input  logic [IDX_W-1:0]              grantMb,
  input  logic [IDX_W-1:0]              curMb,
  output logic [NUM_MB-1:0]             pendVec,
  output logic [NUM_MB-1:0]             cancelVec,
  output logic [NUM_MB-1:0][PRIO_W-1:0] prio,
  output logic [NUM_MB-1:0]             mbReady,
  output logic [NUM_MB-1:0]             mbAbort,
  output logic [NUM_MB-1:0]             irqPend,
  output logic [ID_W-1:0]               txIdWord,
  output logic                          txRemote,
  output logic [LEN_W-1:0]              txLen,
  output logic [2*WORD_W-1:0]           txData
);

  logic [ID_W-1:0]     idArr  [NUM_MB];
  logic [WORD_W-1:0]   loArr  [NUM_MB];
  logic [WORD_W-1:0]   hiArr  [NUM_MB];
  logic [LEN_W-1:0]    lenArr [NUM_MB];
  logic [NUM_MB-1:0]   rtrVec;
  logic                finishAny;

  assign finishAny = strobe.finishOk || strobe.finishAbort;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic              enQ, pendQ, readyQ, abortQ, irqQ, rtrQ;
    logic [PRIO_W-1:0] prioQ;
    logic [ID_W-1:0]   idQ;
    logic [WORD_W-1:0] loQ, hiQ;
    logic [LEN_W-1:0]  lenQ;
    logic              hit, cfgWr, idWr, loWr, hiWr, ctrlWr;
    logic              startCmd, cancelCmd, grantMe, finMe;

    assign hit       = wrEn && (wrMb == IDX_W'(g));
    assign cfgWr     = hit && (wrReg == REG_CFG);
    assign idWr      = hit && (wrReg == REG_ID) && !enQ;
    assign loWr      = hit && (wrReg == REG_DLO);
    assign hiWr      = hit && (wrReg == REG_DHI);
    assign ctrlWr    = hit && (wrReg == REG_CTRL);
    assign startCmd  = ctrlWr && wrData[CTRL_START_BIT] && enQ && readyQ;
    assign cancelCmd = ctrlWr && !wrData[CTRL_START_BIT] &&
                       wrData[CTRL_CANCEL_BIT] && pendQ;
    assign grantMe   = strobe.grant && (grantMb == IDX_W'(g));
    assign finMe     = finishAny && (curMb == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ    <= 1'b0;
        prioQ  <= '0;
        idQ    <= '0;
        loQ    <= '0;
        hiQ    <= '0;
        lenQ   <= '0;
        rtrQ   <= 1'b0;
        pendQ  <= 1'b0;
        readyQ <= 1'b1;
        abortQ <= 1'b0;
        irqQ   <= 1'b0;
      end else begin
        if (cfgWr) begin
          enQ   <= wrData[CFG_EN_BIT];
          prioQ <= wrData[PRIO_W-1:0];
        end
        if (idWr) idQ <= wrData[ID_W-1:0];
        if (loWr) loQ <= wrData;
        if (hiWr) hiQ <= wrData;

        if (startCmd) begin
          lenQ   <= wrData[CTRL_LEN_LSB +: LEN_W];
          rtrQ   <= wrData[CTRL_RTR_BIT];
          pendQ  <= 1'b1;
          readyQ <= 1'b0;
          abortQ <= 1'b0;
        end else if (cancelCmd) begin
          pendQ  <= 1'b0;
          readyQ <= 1'b1;
          abortQ <= 1'b1;
        end else if (grantMe) begin
          pendQ  <= 1'b0;
        end

        if (finMe) begin
          readyQ <= 1'b1;
          abortQ <= strobe.finishAbort;
        end

        if (finMe || cancelCmd) irqQ <= 1'b1;
        else if (irqAck[g])     irqQ <= 1'b0;
      end
    end

    assign pendVec[g]   = pendQ;
    assign cancelVec[g] = cancelCmd;
    assign prio[g]      = prioQ;
    assign mbReady[g]   = readyQ;
    assign mbAbort[g]   = abortQ;
    assign irqPend[g]   = irqQ;
    assign rtrVec[g]    = rtrQ;
    assign idArr[g]     = idQ;
    assign loArr[g]     = loQ;
    assign hiArr[g]     = hiQ;
    assign lenArr[g]    = lenQ;
  end

  // frame captured at grant, held for the whole transfer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txIdWord <= '0;
      txRemote <= 1'b0;
      txLen    <= '0;
      txData   <= '0;
    end else if (strobe.grant) begin
      txIdWord <= idArr[grantMb];
      txRemote <= rtrVec[grantMb];
      txLen    <= lenArr[grantMb];
      txData   <= {hiArr[grantMb], loArr[grantMb]};
    end
  end

endmodule

// File: rtl/can_tx_arbiter.sv
`timescale 1ns/1ps
module can_tx_arbiter
  import can_txarb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  parameter int ID_W   = 30,
  parameter int LEN_W  = 4,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrMb,
  input  logic [2:0]          wrReg,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [NUM_MB-1:0]   irqAck,
  output logic [NUM_MB-1:0]   mbReady,
  output logic [NUM_MB-1:0]   mbAbort,
  output logic [NUM_MB-1:0]   irqPend,
  output logic                txValid,
  output logic [IDX_W-1:0]    txMb,
  output logic [ID_W-1:0]     txIdWord,
  output logic                txRemote,
  output logic [LEN_W-1:0]    txLen,
  output logic [2*WORD_W-1:0] txData,
  input  logic                txDone,
  input  logic                txAbort
);

  arbStrobe_t                    strobe;
  logic [IDX_W-1:0]              grantMb;
  logic [NUM_MB-1:0]             pendVec;
  logic [NUM_MB-1:0]             cancelVec;
  logic [NUM_MB-1:0][PRIO_W-1:0] prio;

  can_txarb_ctrl #(
    .NUM_MB(NUM_MB),
    .PRIO_W(PRIO_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pendVec  (pendVec),
    .cancelVec(cancelVec),
    .prio     (prio),
    .txDone   (txDone),
    .txAbort  (txAbort),
    .strobe   (strobe),
    .grantMb  (grantMb),
    .curMb    (txMb),
    .busy     (txValid)
  );

  can_txarb_dp #(
    .NUM_MB(NUM_MB),
    .PRIO_W(PRIO_W),
    .ID_W  (ID_W),
    .LEN_W (LEN_W),
    .WORD_W(WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrMb     (wrMb),
    .wrReg    (wrReg),
    .wrData   (wrData),
    .irqAck   (irqAck),
    .strobe   (strobe),
    .grantMb  (grantMb),
    .curMb    (txMb),
    .pendVec  (pendVec),
    .cancelVec(cancelVec),
    .prio     (prio),
    .mbReady  (mbReady),
    .mbAbort  (mbAbort),
    .irqPend  (irqPend),
    .txIdWord (txIdWord),
    .txRemote (txRemote),
    .txLen    (txLen),
    .txData   (txData)
  );

endmodule

// File: rtl/can_tx_arbiter_chk.sv
`timescale 1ns/1ps
module can_tx_arbiter_chk #(
  parameter int NUM_MB = 4,
  parameter int ID_W   = 30,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input logic                clk,
  input logic                rstN,
  input logic                txValid,
  input logic [IDX_W-1:0]    txMb,
  input logic                txDone,
  input logic                txAbort,
  input logic [ID_W-1:0]     txIdWord,
  input logic [2*WORD_W-1:0] txData,
  input logic [NUM_MB-1:0]   mbReady,
  input logic [NUM_MB-1:0]   mbAbort,
  input logic [NUM_MB-1:0]   irqPend,
  input logic [NUM_MB-1:0]   irqAck
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!txValid && (mbReady == '1) && (irqPend == '0)));

  assert_inflight_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !mbReady[txMb]);

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txDone && !txAbort) |=>
      (txValid && $stable(txMb) && $stable(txIdWord) && $stable(txData)));

  assert_done_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txDone) |=>
      (!txValid && mbReady[$past(txMb)] && !mbAbort[$past(txMb)] &&
       irqPend[$past(txMb)]));

  assert_abort_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txDone && txAbort) |=>
      (!txValid && mbReady[$past(txMb)] && mbAbort[$past(txMb)] &&
       irqPend[$past(txMb)]));

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((irqPend & ~irqAck) != '0) |=>
      ((($past(irqPend) & ~$past(irqAck)) & ~irqPend) == '0));

endmodule

bind can_tx_arbiter can_tx_arbiter_chk #(
  .NUM_MB(NUM_MB),
  .ID_W  (ID_W),
  .WORD_W(WORD_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .txValid (txValid),
  .txMb    (txMb),
  .txDone  (txDone),
  .txAbort (txAbort),
  .txIdWord(txIdWord),
  .txData  (txData),
  .mbReady (mbReady),
  .mbAbort (mbAbort),
  .irqPend (irqPend),
  .irqAck  (irqAck)
);

// File: tb/sim_can_tx_arbiter.sv
`timescale 1ns/1ps
module sim_can_tx_arbiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrMb = '0;
  logic [2:0]  wrReg = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  irqAck = '0;
  logic        txDone = 1'b0;
  logic        txAbort = 1'b0;
  logic [3:0]  mbReady, mbAbort, irqPend;
  logic        txValid, txRemote;
  logic [1:0]  txMb;
  logic [29:0] txIdWord;
  logic [3:0]  txLen;
  logic [63:0] txData;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  can_tx_arbiter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMb(wrMb), .wrReg(wrReg),
    .wrData(wrData), .irqAck(irqAck), .mbReady(mbReady), .mbAbort(mbAbort),
    .irqPend(irqPend), .txValid(txValid), .txMb(txMb), .txIdWord(txIdWord),
    .txRemote(txRemote), .txLen(txLen), .txData(txData),
    .txDone(txDone), .txAbort(txAbort)
  );

  // {arm mask, urgency mb3..mb0 (4 bits each), expected first winner}
  localparam logic [21:0] VEC [9] = '{
    {4'b0001, 16'h5555, 2'd0},
    {4'b1011, 16'h1213, 2'd1},
    {4'b1100, 16'h4900, 2'd3},
    {4'b1010, 16'hF0F0, 2'd1},
    {4'b0111, 16'h7777, 2'd0},
    {4'b0110, 16'h0880, 2'd1},
    {4'b1001, 16'h0002, 2'd3},
    {4'b1110, 16'hFEF0, 2'd2},
    {4'b0101, 16'h030C, 2'd2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWr(input int mb, input int sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrMb = 2'(mb); wrReg = 3'(sel); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfgMb(input int mb, input bit en, input int p);
    hostWr(mb, 0, (32'(en) << 8) | 32'(p & 15));
  endtask

  task automatic startMb(input int mb, input int len, input bit rtr);
    hostWr(mb, 4, (32'd1 << 23) | (32'(rtr) << 20) | (32'(len & 15) << 16));
  endtask

  task automatic waitValid();
    for (int k = 0; k < 20 && !txValid; k++) @(negedge clk);
  endtask

  task automatic endFrame(input bit ok);
    @(negedge clk);
    txDone = ok; txAbort = !ok;
    @(negedge clk);
    txDone = 1'b0; txAbort = 1'b0;
  endtask

  task automatic ackAll();
    @(negedge clk);
    irqAck = 4'hF;
    @(negedge clk);
    irqAck = 4'h0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference choice from R4/R5: smallest urgency, then lowest index
  function automatic int refPick(input logic [3:0] m, input logic [15:0] p);
    int best = -1;
    for (int i = 0; i < 4; i++)
      if (m[i] && (best < 0 || p[i*4 +: 4] < p[best*4 +: 4])) best = i;
    return best;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(mbReady), 64'hF);
    chk("R1 abort", 64'(mbAbort), 64'h0);
    chk("R1 irq", 64'(irqPend), 64'h0);
    chk("R1 valid", 64'(txValid), 64'h0);

    // table walk: R4/R5 ordering under a busy engine
    foreach (VEC[v]) begin
      logic [3:0]  m;
      logic [15:0] p;
      logic [1:0]  ex;
      logic [3:0]  left;
      int blk;
      int nxt;
      m = VEC[v][21:18]; p = VEC[v][17:2]; ex = VEC[v][1:0];
      blk = 0;
      for (int i = 0; i < 4; i++) if (!m[i]) blk = i;
      for (int i = 0; i < 4; i++) cfgMb(i, 1'b1, int'(p[i*4 +: 4]));
      startMb(blk, 8, 1'b0);
      waitValid();
      chk("R3 blocker mailbox", 64'(txMb), 64'(blk));
      for (int i = 0; i < 4; i++) if (m[i]) startMb(i, 2, 1'b0);
      repeat (2) @(negedge clk);
      endFrame(1'b1);
      waitValid();
      chk("R4/R5 first winner", 64'(txMb), 64'(ex));
      left = m & ~(4'b1 << ex);
      endFrame(1'b1);
      while (left != 0) begin
        nxt = refPick(left, p);
        waitValid();
        chk("R4/R5 drain order", 64'(txMb), 64'(nxt));
        left = left & ~(4'b1 << nxt);
        endFrame(1'b1);
      end
      chk("R7 all ready", 64'(mbReady), 64'hF);
      chk("R11 irq set", 64'(irqPend), 64'(m | (4'b1 << blk)));
      ackAll();
    end

    // R2: start on a disabled mailbox is ignored
    cfgMb(0, 1'b0, 0);
    startMb(0, 3, 1'b0);
    repeat (2) @(negedge clk);
    chk("R2 disabled ready", 64'(mbReady[0]), 64'h1);
    chk("R2 disabled no frame", 64'(txValid), 64'h0);

    // R9 and R3: identifier guard and frame fields
    cfgMb(1, 1'b0, 4);
    hostWr(1, 1, 32'h2ABC_DEF1);
    cfgMb(1, 1'b1, 4);
    hostWr(1, 1, 32'h0000_0123);
    hostWr(1, 2, 32'h1122_3344);
    hostWr(1, 3, 32'h5566_7788);
    startMb(1, 5, 1'b1);
    waitValid();
    chk("R3 mailbox", 64'(txMb), 64'h1);
    chk("R9 id guard", 64'(txIdWord), 64'h2ABC_DEF1);
    chk("R3 length", 64'(txLen), 64'h5);
    chk("R3 remote", 64'(txRemote), 64'h1);
    chk("R3 data", txData, 64'h5566_7788_1122_3344);
    chk("R2 inflight not ready", 64'(mbReady[1]), 64'h0);
    endFrame(1'b1);
    chk("R7 valid drops", 64'(txValid), 64'h0);
    chk("R7 ready", 64'(mbReady[1]), 64'h1);
    chk("R7 abort clear", 64'(mbAbort[1]), 64'h0);
    chk("R7 irq", 64'(irqPend[1]), 64'h1);
    repeat (5) @(negedge clk);
    chk("R11 irq held", 64'(irqPend[1]), 64'h1);
    @(negedge clk); irqAck = 4'b0010;
    @(negedge clk); irqAck = 4'b0000;
    chk("R11 irq acked", 64'(irqPend), 64'h0);

    // R8: engine abort
    cfgMb(2, 1'b1, 0);
    startMb(2, 1, 1'b0);
    waitValid();
    endFrame(1'b0);
    chk("R8 abort flag", 64'(mbAbort[2]), 64'h1);
    chk("R8 ready", 64'(mbReady[2]), 64'h1);
    chk("R8 irq", 64'(irqPend[2]), 64'h1);
    ackAll();

    // R6: no pre-emption by a later, more urgent mailbox
    cfgMb(3, 1'b1, 15);
    startMb(3, 1, 1'b0);
    waitValid();
    cfgMb(1, 1'b1, 0);
    startMb(1, 1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 still valid", 64'(txValid), 64'h1);
    chk("R6 same mailbox", 64'(txMb), 64'h3);
    endFrame(1'b1);
    waitValid();
    chk("R6 next mailbox", 64'(txMb), 64'h1);
    endFrame(1'b1);
    ackAll();

    // R10: cancel a waiting mailbox, then try it on the one in flight
    cfgMb(0, 1'b1, 1);
    startMb(0, 1, 1'b0);
    waitValid();
    cfgMb(2, 1'b1, 0);
    startMb(2, 1, 1'b0);
    hostWr(2, 4, 32'd1 << 22);
    chk("R10 cancel ready", 64'(mbReady[2]), 64'h1);
    chk("R10 cancel abort", 64'(mbAbort[2]), 64'h1);
    chk("R10 cancel irq", 64'(irqPend[2]), 64'h1);
    hostWr(0, 4, 32'd1 << 22);
    chk("R10 inflight ready", 64'(mbReady[0]), 64'h0);
    chk("R10 inflight abort", 64'(mbAbort[0]), 64'h0);
    chk("R10 inflight kept", 64'({txValid, txMb}), 64'h4);
    endFrame(1'b1);
    repeat (3) @(negedge clk);
    chk("R10 cancelled never sent", 64'(txValid), 64'h0);
    ackAll();

    summary();
  end

endmodule